// File: doc/BRIEF.md
# Four-Channel Event Framer with Occupancy Interrupt

The block takes 32-bit event words from up to four front-end channels. Each channel has a valid/ready stream, and a last flag marks the final payload word of an event. On each channel the framer first stores an opening word, then the payload words, then a closing word, all in that channel's own data FIFO. When the closing word is written, it also pushes the event's total word count into a second, smaller per-channel FIFO. The host can then learn event sizes without looking at the data.

A counter keeps the number of data words held across all data FIFOs. It takes several writes and one read in the same cycle without losing a count. A level interrupt is high while this total is above a programmable threshold. A host read port picks one channel and can pop that channel's length FIFO, its data FIFO, or both. The host sums the lengths it pops to size one bulk transfer. When a channel cannot store its next word, the channel stalls its stream and raises a stall flag. No word is ever dropped.

Top module: `evt_framer`

## Requirements
- R1: The first word stored for an event is the opening word {8'hE5, channel index (8 bits), event number (16 bits)}. The event number of each channel starts at 0 after reset and goes up by one for each completed event.
- R2: Payload words are accepted only on a cycle where in_valid and in_ready are both high, and are stored in arrival order after the opening word. in_ready is low in the cycle that writes the opening word and in the cycle that writes the closing word.
- R3: After the word flagged last, the closing word {8'hF0, 8'h00, payload word count (16 bits)} is stored.
- R4: In the cycle the closing word is stored, the length FIFO of that channel receives the payload count plus 2.
- R5: total always equals the number of words held in all data FIFOs. It is updated on the clock edge of each write and read, including several writes and a read in the same cycle.
- R6: irq is high exactly when total is above threshold. It changes on the same edge as total, using the threshold present at that edge.
- R7: A channel whose data FIFO is full (16 words) accepts no word, holds in_ready low and drives its stall bit high while it has a word waiting. A channel waiting to write a closing word also stalls while its length FIFO is full (4 entries). After a stall, no word is lost or reordered.
- R8: dat_data and len_data show the oldest entry of the channel picked by rd_sel. dat_pop and len_pop remove that entry. A pop on an empty FIFO changes nothing.
- R9: After reset, total is 0, irq is 0, every FIFO is empty, and in_ready and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NCH | Per-channel word valid |
| in_last | input | NCH | Per-channel last payload word of the event |
| in_data | input | NCH*32 | Per-channel payload words, channel c in bits [32c+31:32c] |
| in_ready | output | NCH | Per-channel payload word accepted when high with in_valid |
| stall | output | NCH | Per-channel backpressure: a word is waiting for FIFO space |
| threshold | input | TW | Interrupt threshold on total |
| rd_sel | input | SELW | Channel picked for host reads |
| dat_pop | input | 1 | Pop the picked data FIFO |
| len_pop | input | 1 | Pop the picked length FIFO |
| dat_empty | output | NCH | Per-channel data FIFO empty |
| len_empty | output | NCH | Per-channel length FIFO empty |
| dat_data | output | 32 | Oldest data word of the picked channel |
| len_data | output | 16 | Oldest length of the picked channel |
| total | output | TW | Words held in all data FIFOs |
| irq | output | 1 | High while total is above threshold |

## Verification
A wrong pointer or count inside a FIFO shows up at the ports as a wrong head word, a wrong empty flag or a wrong total. The bench compares all of these against a behavioural queue model on every clock, so such an error is caught in the cycle it first becomes visible. A framer phase that drifts from the model shows at once as a wrong in_ready or stall level, or later as a wrong closing word or length. The error is caught no later than the pop that brings the word to the head. A lost count in the total shows as a total or irq mismatch on the very next clock.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam logic [7:0] OPEN_MARK  = 8'hE5;
  localparam logic [7:0] CLOSE_MARK = 8'hF0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BODY = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;

  function automatic logic [WORD_W-1:0] open_word(input logic [7:0] ch, input logic [15:0] num);
    return {OPEN_MARK, ch, num};
  endfunction

  function automatic logic [WORD_W-1:0] close_word(input logic [15:0] cnt);
    return {CLOSE_MARK, 8'h00, cnt};
  endfunction
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign rd_data = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en) wptr_d = (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
    if (rd_en) rptr_d = (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty); // R8
endmodule

// File: rtl/evt_chan_framer.sv
module evt_chan_framer
  import evt_framer_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [WORD_W-1:0] in_data,
  input  logic              dfull,
  input  logic              lfull,
  output logic              in_ready,
  output logic              stall,
  output logic              dwr_en,
  output logic [WORD_W-1:0] dwr_data,
  output logic              lwr_en,
  output logic [LEN_W-1:0]  lwr_data
);
  phase_e      phase_q, phase_d;
  logic [15:0] pcnt_q, pcnt_d;
  logic [15:0] evnum_q, evnum_d;

  always_comb begin
    phase_d  = phase_q;
    pcnt_d   = pcnt_q;
    evnum_d  = evnum_q;
    in_ready = 1'b0;
    stall    = 1'b0;
    dwr_en   = 1'b0;
    dwr_data = '0;
    lwr_en   = 1'b0;
    lwr_data = '0;
    case (phase_q)
      PH_IDLE: begin
        stall = in_valid && dfull;
        if (in_valid && !dfull) begin
          dwr_en   = 1'b1;
          dwr_data = open_word(8'(CH_IDX), evnum_q);
          pcnt_d   = '0;
          phase_d  = PH_BODY;
        end
      end
      PH_BODY: begin
        in_ready = !dfull;
        stall    = in_valid && dfull;
        if (in_valid && !dfull) begin
          dwr_en   = 1'b1;
          dwr_data = in_data;
          pcnt_d   = pcnt_q + 1'b1;
          if (in_last) phase_d = PH_TAIL;
        end
      end
      PH_TAIL: begin
        stall = dfull || lfull;
        if (!dfull && !lfull) begin
          dwr_en   = 1'b1;
          dwr_data = close_word(pcnt_q);
          lwr_en   = 1'b1;
          lwr_data = LEN_W'(pcnt_q) + LEN_W'(2);
          evnum_d  = evnum_q + 1'b1;
          phase_d  = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pcnt_q  <= '0;
      evnum_q <= '0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      evnum_q <= evnum_d;
    end
  end

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !in_ready); // R7
  AST_LEN_WITH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) lwr_en |-> dwr_en); // R4
  AST_READY_NOT_TAIL: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> !lwr_en); // R2
endmodule

// File: rtl/evt_framer.sv
module evt_framer
  import evt_framer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DDEPTH = 16,
  parameter int LDEPTH = 4,
  localparam int SELW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW    = $clog2(NCH * DDEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        in_valid,
  input  logic [NCH-1:0]        in_last,
  input  logic [NCH*WORD_W-1:0] in_data,
  output logic [NCH-1:0]        in_ready,
  output logic [NCH-1:0]        stall,
  input  logic [TW-1:0]         threshold,
  input  logic [SELW-1:0]       rd_sel,
  input  logic                  dat_pop,
  input  logic                  len_pop,
  output logic [NCH-1:0]        dat_empty,
  output logic [NCH-1:0]        len_empty,
  output logic [WORD_W-1:0]     dat_data,
  output logic [LEN_W-1:0]      len_data,
  output logic [TW-1:0]         total,
  output logic                  irq
);
  localparam logic [TW-1:0] CAP = TW'(NCH * DDEPTH);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NCH-1:0]    dwr, lwr, dfull, lfull, drd, lrd;
  logic [WORD_W-1:0] dwr_data [NCH];
  logic [WORD_W-1:0] drd_data [NCH];
  logic [LEN_W-1:0]  lwr_data [NCH];
  logic [LEN_W-1:0]  lrd_data [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    evt_chan_framer #(.CH_IDX(c)) u_framer (
      .clk(clk), .rst_n(rst_n_s),
      .in_valid(in_valid[c]), .in_last(in_last[c]),
      .in_data(in_data[c*WORD_W +: WORD_W]),
      .dfull(dfull[c]), .lfull(lfull[c]),
      .in_ready(in_ready[c]), .stall(stall[c]),
      .dwr_en(dwr[c]), .dwr_data(dwr_data[c]),
      .lwr_en(lwr[c]), .lwr_data(lwr_data[c])
    );

    assign drd[c] = dat_pop && (rd_sel == SELW'(c)) && !dat_empty[c];
    assign lrd[c] = len_pop && (rd_sel == SELW'(c)) && !len_empty[c];

    evt_fifo #(.W(WORD_W), .DEPTH(DDEPTH)) u_dfifo (
      .clk(clk), .rst_n(rst_n_s),
      .wr_en(dwr[c]), .wr_data(dwr_data[c]),
      .rd_en(drd[c]), .rd_data(drd_data[c]),
      .empty(dat_empty[c]), .full(dfull[c])
    );

    evt_fifo #(.W(LEN_W), .DEPTH(LDEPTH)) u_lfifo (
      .clk(clk), .rst_n(rst_n_s),
      .wr_en(lwr[c]), .wr_data(lwr_data[c]),
      .rd_en(lrd[c]), .rd_data(lrd_data[c]),
      .empty(len_empty[c]), .full(lfull[c])
    );
  end

  always_comb begin
    dat_data = '0;
    len_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_sel == SELW'(c)) begin
        dat_data = drd_data[c];
        len_data = lrd_data[c];
      end
    end
  end

  logic [TW-1:0] total_q, total_d, n_wr, n_rd;
  logic          irq_q, irq_d;

  always_comb begin
    n_wr = '0;
    n_rd = '0;
    for (int c = 0; c < NCH; c++) begin
      n_wr = n_wr + TW'(dwr[c]);
      n_rd = n_rd + TW'(drd[c]);
    end
    total_d = total_q + n_wr - n_rd;
    irq_d   = (total_d > threshold);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      total_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      total_q <= total_d;
      irq_q   <= irq_d;
    end
  end

  assign total = total_q;
  assign irq   = irq_q;

  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n_s) total <= CAP); // R5
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n_s) irq |-> (total != '0)); // R6
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n_s) $onehot0(drd)); // R8
  AST_EMPTY_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s) (&dat_empty) |-> (total == '0)); // R5
endmodule

// File: tb/tb_evt_framer.sv
module tb_evt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DEPTH = 16;
  localparam int LDEPTH = 4;
  localparam int TW = $clog2(NCH * DEPTH + 1);

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rst_n;
  logic [NCH-1:0]    in_valid, in_last, in_ready, stall, dat_empty, len_empty;
  logic [NCH*32-1:0] in_data;
  logic [TW-1:0]     threshold, total;
  logic [1:0]        rd_sel;
  logic              dat_pop, len_pop, irq;
  logic [31:0]       dat_data;
  logic [15:0]       len_data;

  evt_framer #(.NCH(NCH), .DDEPTH(DEPTH), .LDEPTH(LDEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .in_ready(in_ready), .stall(stall),
    .threshold(threshold), .rd_sel(rd_sel), .dat_pop(dat_pop),
    .len_pop(len_pop), .dat_empty(dat_empty), .len_empty(len_empty),
    .dat_data(dat_data), .len_data(len_data), .total(total), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: queues of stored words and lengths per channel
  int          ph [NCH];
  int          pc [NCH];
  int          en [NCH];
  int          ds [NCH];
  int          ls [NCH];
  logic [31:0] dq [NCH][$];
  int          lq [NCH][$];
  logic [31:0] sw [NCH][$];
  bit          sl [NCH][$];
  bit          m_irq;
  int          m_total;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ph[c] = 0; pc[c] = 0; en[c] = 0;
        dq[c].delete(); lq[c].delete();
      end
      m_irq = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        ds[c] = dq[c].size();
        ls[c] = lq[c].size();
      end
      if (dat_pop && dq[rd_sel].size() > 0) void'(dq[rd_sel].pop_front());
      if (len_pop && lq[rd_sel].size() > 0) void'(lq[rd_sel].pop_front());
      for (int c = 0; c < NCH; c++) begin
        case (ph[c])
          0: if (in_valid[c] && ds[c] < DEPTH) begin
               dq[c].push_back({8'hE5, 8'(c), 16'(en[c])});
               ph[c] = 1; pc[c] = 0;
             end
          1: if (in_valid[c] && ds[c] < DEPTH) begin
               dq[c].push_back(in_data[c*32 +: 32]);
               pc[c]++;
               void'(sw[c].pop_front());
               void'(sl[c].pop_front());
               if (in_last[c]) ph[c] = 2;
             end
          default: if (ds[c] < DEPTH && ls[c] < LDEPTH) begin
               dq[c].push_back({8'hF0, 8'h00, 16'(pc[c])});
               lq[c].push_back(pc[c] + 2);
               en[c]++; ph[c] = 0;
             end
        endcase
      end
      m_total = 0;
      for (int c = 0; c < NCH; c++) m_total += dq[c].size();
      m_irq = (m_total > int'(threshold));
    end
  end

  // source driver, after each edge
  always @(posedge clk) begin
    #2;
    for (int c = 0; c < NCH; c++) begin
      if (rst_n && sw[c].size() > 0) begin
        in_valid[c] = 1'b1;
        in_data[c*32 +: 32] = sw[c][0];
        in_last[c] = sl[c][0];
      end else begin
        in_valid[c] = 1'b0;
        in_data[c*32 +: 32] = '0;
        in_last[c] = 1'b0;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int sum;
      sum = 0;
      for (int c = 0; c < NCH; c++) sum += dq[c].size();
      chk("R5 total", 64'(total), 64'(sum));
      chk("R6 irq", 64'(irq), 64'(m_irq));
      for (int c = 0; c < NCH; c++) begin
        bit dfull, lfull, exp_st;
        dfull = dq[c].size() >= DEPTH;
        lfull = lq[c].size() >= LDEPTH;
        exp_st = (ph[c] == 2) ? (dfull || lfull) : (in_valid[c] && dfull);
        chk("R2 in_ready", 64'(in_ready[c]), 64'(ph[c] == 1 && !dfull));
        chk("R7 stall", 64'(stall[c]), 64'(exp_st));
        chk("R8 dat_empty", 64'(dat_empty[c]), 64'(dq[c].size() == 0));
        chk("R4 len_empty", 64'(len_empty[c]), 64'(lq[c].size() == 0));
      end
      if (dq[rd_sel].size() > 0) chk("R8 dat_data", 64'(dat_data), 64'(dq[rd_sel][0]));
      if (lq[rd_sel].size() > 0) chk("R4 len_data", 64'(len_data), 64'(lq[rd_sel][0]));
    end
  end

  task automatic send(input int c, input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      sw[c].push_back(base + 32'(i));
      sl[c].push_back(i == n - 1);
    end
  endtask

  task automatic settle();
    forever begin
      bit busy;
      busy = 0;
      for (int c = 0; c < NCH; c++) if (sw[c].size() > 0 || ph[c] != 0) busy = 1;
      if (!busy) break;
      @(posedge clk);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop_dat(input int c, input int n);
    @(posedge clk); #2;
    rd_sel = 2'(c); dat_pop = 1'b1;
    repeat (n) @(posedge clk);
    #2 dat_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_len(input int c);
    @(posedge clk); #2;
    rd_sel = 2'(c); len_pop = 1'b1;
    @(posedge clk);
    #2 len_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sel(input int c);
    @(posedge clk); #2 rd_sel = 2'(c);
    @(negedge clk);
  endtask

  task automatic run_tests();
    logic [31:0] exp_w;
    int t0;
    rst_n = 1'b0; in_valid = '0; in_last = '0; in_data = '0;
    threshold = TW'(100); rd_sel = '0; dat_pop = 1'b0; len_pop = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 total", 64'(total), 64'd0);
    chk("R9 irq", 64'(irq), 64'd0);
    chk("R9 dat_empty", 64'(dat_empty), 64'hF);
    chk("R9 len_empty", 64'(len_empty), 64'hF);
    chk("R9 in_ready", 64'(in_ready), 64'd0);
    chk("R9 stall", 64'(stall), 64'd0);

    // single event on channel 0
    send(0, 3, 32'h1000_0000);
    settle();
    chk("R5 total after event", 64'(total), 64'd5);
    chk("R1 opening word ch0 ev0", 64'(dat_data), 64'hE500_0000);
    chk("R4 length ch0", 64'(len_data), 64'd5);
    pop_dat(0, 1);
    chk("R2 first payload", 64'(dat_data), 64'h1000_0000);
    pop_dat(0, 3);
    chk("R3 closing word", 64'(dat_data), 64'hF000_0003);
    pop_dat(0, 1);
    pop_len(0);
    chk("R8 drained ch0", 64'({dat_empty[0], len_empty[0]}), 64'd3);

    // all channels at once
    send(0, 2, 32'hA000_0000);
    send(1, 4, 32'hB000_0000);
    send(2, 6, 32'hC000_0000);
    send(3, 1, 32'hD000_0000);
    settle();
    chk("R5 concurrent total", 64'(total), 64'd21);
    chk("R1 opening word ch0 ev1", 64'(dat_data), 64'hE500_0001);
    set_sel(2);
    chk("R1 opening word ch2", 64'(dat_data), 64'hE502_0000);
    chk("R4 length ch2", 64'(len_data), 64'd8);
    @(posedge clk); #2 threshold = TW'(10);
    @(posedge clk); @(negedge clk);
    chk("R6 irq above", 64'(irq), 64'd1);
    pop_dat(3, 3);
    pop_dat(2, 7);
    chk("R6 total 11", 64'(total), 64'd11);
    chk("R6 irq at 11", 64'(irq), 64'd1);
    pop_dat(2, 1);
    chk("R6 irq at threshold", 64'(irq), 64'd0);
    pop_dat(0, 4);
    pop_dat(1, 6);
    for (int c = 0; c < NCH; c++) pop_len(c);

    // writes and reads in the same cycles
    threshold = TW'(100);
    send(1, 8, 32'h2000_0000);
    send(2, 3, 32'h3000_0000);
    @(posedge clk); #2 rd_sel = 2'd1; dat_pop = 1'b1;
    repeat (12) @(posedge clk);
    #2 dat_pop = 1'b0;
    settle();
    t0 = dq[1].size() + dq[2].size();
    chk("R5 mixed total", 64'(total), 64'(t0));
    pop_dat(1, dq[1].size());
    pop_dat(2, 5);
    pop_len(1); pop_len(2);

    // data FIFO full on channel 1
    threshold = TW'(127);
    send(1, 20, 32'h4000_0000);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R7 stall when full", 64'(stall[1]), 64'd1);
    chk("R7 ready low when full", 64'(in_ready[1]), 64'd0);
    chk("R7 total capped", 64'(total), 64'd16);
    set_sel(1);
    for (int i = 0; i < 22; i++) begin
      if (i == 0) exp_w = 32'hE501_0002;
      else if (i == 21) exp_w = 32'hF000_0014;
      else exp_w = 32'h4000_0000 + 32'(i - 1);
      chk("R7 word order after stall", 64'(dat_data), 64'(exp_w));
      pop_dat(1, 1);
    end
    chk("R4 length after stall", 64'(len_data), 64'd22);
    pop_len(1);

    // length FIFO full on channel 2
    for (int k = 0; k < 5; k++) send(2, 1, 32'h5000_0000 + 32'(k));
    repeat (25) @(posedge clk);
    @(negedge clk);
    chk("R7 stall on length full", 64'(stall[2]), 64'd1);
    chk("R7 total on length full", 64'(total), 64'd14);
    pop_len(2);
    settle();
    chk("R7 resumed", 64'(total), 64'd15);

    // threshold boundary
    @(posedge clk); #2 threshold = TW'(14);
    @(posedge clk); @(negedge clk);
    chk("R6 irq 15>14", 64'(irq), 64'd1);
    @(posedge clk); #2 threshold = TW'(15);
    @(posedge clk); @(negedge clk);
    chk("R6 irq 15=15", 64'(irq), 64'd0);

    // pop on an empty channel
    set_sel(3);
    @(posedge clk); #2 dat_pop = 1'b1; len_pop = 1'b1;
    @(posedge clk); #2 dat_pop = 1'b0; len_pop = 1'b0;
    @(negedge clk);
    chk("R8 empty pop total", 64'(total), 64'd15);
    chk("R8 empty pop flags", 64'({dat_empty[3], len_empty[3]}), 64'd3);
    chk("R8 other channel kept", 64'(dat_empty[2]), 64'd0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule